// File: doc/BRIEF.md
# FR-FCFS DRAM Request Picker

This unit picks the next request to issue from one DRAM controller request queue. The queue arrives as a flat snapshot in arrival order, with a valid bit, a bank index and a row address for each slot. Alongside the queue come two per-bank values: the row each bank holds open and the cycle at which each bank becomes idle. The current cycle count is a separate input. A single instance serves either a read queue or a write queue, because both use the same logic.

A one-cycle strobe starts a pick. In first-come-first-served mode the unit always takes the head slot. In FR-FCFS mode it first looks for the oldest slot that hits its bank's open row. If there is no hit, it falls back to the oldest slot whose bank is already idle or whose bank ties for the earliest idle time among the banks the queue uses.

One cycle after the strobe, the unit presents the chosen slot index and the reordered queue. In the reordered queue the chosen slot sits at the head and every other slot keeps its relative order. The controller writes this back as its new queue.

Top module: `frfcfs_picker`

## Requirements
- R1: While reset is held and after it is released, `pick_valid` is 0 and `ord_valid` is all zeros until the first pick.
- R2: With `sched_mode` = 0 (FCFS), a pick returns index 0 and the reordered queue equals the input queue.
- R3: With `sched_mode` = 1 (FR-FCFS), a slot is a row hit when `bank_open_row` of its bank equals its row. The lowest-index valid row-hit slot is chosen.
- R4: A row hit is chosen even when a lower-index slot meets the fallback condition.
- R5: With no row hit, the lowest-index valid slot is chosen whose bank idle time is at or below `now_cycle`, or whose bank is in the earliest-idle set.
- R6: The earliest-idle set holds every bank referenced by a valid slot whose idle time equals the minimum over those referenced banks. Ties put several banks in the set.
- R7: In the reordered queue, slot 0 holds the chosen entry, slots 1 up to the chosen index hold the entries that were one position lower, and higher slots are unchanged. Valid bits, banks and rows all move together.
- R8: The result registers one cycle after `pick_req`. `pick_valid` is high for exactly that one cycle, and no output responds combinationally to the request.
- R9: A pick on an empty queue (`ent_valid[0]` = 0) leaves `pick_valid` at 0 and leaves the reordered-queue outputs unchanged.
- R10: Invalid slots are never chosen, even when they hit an open row. Their banks do not affect the earliest-idle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sched_mode | input | 1 | 0 = FCFS, 1 = FR-FCFS |
| pick_req | input | 1 | Pick strobe |
| now_cycle | input | TIME_W | Current cycle count |
| ent_valid | input | DEPTH | Slot valid bits, contiguous from slot 0 |
| ent_bank | input | DEPTH*BANK_W | Bank index per slot, slot i at bits [i*BANK_W +: BANK_W] |
| ent_row | input | DEPTH*ROW_W | Row per slot, slot i at bits [i*ROW_W +: ROW_W] |
| bank_open_row | input | NBANK*ROW_W | Open row per bank |
| bank_ready_at | input | NBANK*TIME_W | Cycle at which each bank becomes idle |
| pick_valid | output | 1 | One-cycle pulse carrying a result |
| pick_idx | output | IDX_W | Chosen slot index |
| ord_valid | output | DEPTH | Reordered valid bits |
| ord_bank | output | DEPTH*BANK_W | Reordered bank indices |
| ord_row | output | DEPTH*ROW_W | Reordered rows |

## Verification
The assertions check several properties on every cycle:
- the single-cycle result pulse, its absence after an empty-queue strobe, and the FCFS identity;
- that the new head equals the input slot named by the index;
- that the number of valid slots is preserved;
- that a head picked in FR-FCFS mode is a row hit whenever any row hit existed.

Only the bench scenarios can show the finer properties:
- that the oldest hit wins;
- that the fallback takes exactly the oldest idle-or-earliest slot;
- that ties and invalid slots shape the earliest-idle set correctly;
- that the non-chosen slots keep their exact order.

The bench covers these with directed cases and sweeps over every queue length, using narrow row and time ranges so that hits and ties occur often.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
    localparam int DEF_DEPTH  = 16;
    localparam int DEF_NBANK  = 8;
    localparam int DEF_ROW_W  = 16;
    localparam int DEF_TIME_W = 32;

    typedef enum logic {
        MODE_FCFS   = 1'b0,
        MODE_FRFCFS = 1'b1
    } sched_mode_e;
endpackage

// File: rtl/frfcfs_earliest.sv
// Marks every bank used by a valid slot whose idle time equals the minimum
// idle time over all such banks.
module frfcfs_earliest #(
    parameter int DEPTH  = 16,
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int TIME_W = 32
) (
    input  logic [DEPTH-1:0]        ent_valid,
    input  logic [DEPTH*BANK_W-1:0] ent_bank,
    input  logic [NBANK*TIME_W-1:0] bank_ready_at,
    output logic [NBANK-1:0]        early_mask
);
    logic [NBANK-1:0]  used;
    logic [TIME_W-1:0] min_t;
    logic [TIME_W-1:0] t_b;

    always_comb begin
        used = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid[i]) begin
                used[ent_bank[i*BANK_W +: BANK_W]] = 1'b1;
            end
        end
        min_t = '1;
        for (int b = 0; b < NBANK; b++) begin
            t_b = bank_ready_at[b*TIME_W +: TIME_W];
            if (used[b] && (t_b < min_t)) begin
                min_t = t_b;
            end
        end
        for (int b = 0; b < NBANK; b++) begin
            early_mask[b] = used[b] && (bank_ready_at[b*TIME_W +: TIME_W] == min_t);
        end
    end
endmodule

// File: rtl/frfcfs_scan.sv
// Priority scan: oldest row hit first, then oldest idle-or-earliest slot.
module frfcfs_scan #(
    parameter int DEPTH  = 16,
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int TIME_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                    fr_mode,
    input  logic [TIME_W-1:0]       now_cycle,
    input  logic [DEPTH-1:0]        ent_valid,
    input  logic [DEPTH*BANK_W-1:0] ent_bank,
    input  logic [DEPTH*ROW_W-1:0]  ent_row,
    input  logic [NBANK*ROW_W-1:0]  bank_open_row,
    input  logic [NBANK*TIME_W-1:0] bank_ready_at,
    input  logic [NBANK-1:0]        early_mask,
    output logic [IDX_W-1:0]        sel_idx
);
    logic [DEPTH-1:0]  hit;
    logic [DEPTH-1:0]  fit;
    logic [BANK_W-1:0] bk;
    logic              hit_found;
    logic              fit_found;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  fit_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            bk     = ent_bank[i*BANK_W +: BANK_W];
            hit[i] = ent_valid[i] &&
                     (bank_open_row[bk*ROW_W +: ROW_W] == ent_row[i*ROW_W +: ROW_W]);
            fit[i] = ent_valid[i] &&
                     ((bank_ready_at[bk*TIME_W +: TIME_W] <= now_cycle) || early_mask[bk]);
        end
        hit_found = 1'b0;
        fit_found = 1'b0;
        hit_idx   = '0;
        fit_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i] && !hit_found) begin
                hit_found = 1'b1;
                hit_idx   = IDX_W'(i);
            end
            if (fit[i] && !fit_found) begin
                fit_found = 1'b1;
                fit_idx   = IDX_W'(i);
            end
        end
        if (!fr_mode)       sel_idx = '0;
        else if (hit_found) sel_idx = hit_idx;
        else if (fit_found) sel_idx = fit_idx;
        else                sel_idx = '0;
    end
endmodule

// File: rtl/frfcfs_rotate.sv
// Moves slot sel to slot 0 and shifts slots 0..sel-1 up by one.
module frfcfs_rotate #(
    parameter int DEPTH = 16,
    parameter int W     = 1,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]   sel,
    input  logic [DEPTH*W-1:0] din,
    output logic [DEPTH*W-1:0] dout
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        if (k == 0) begin : g_head
            assign dout[0 +: W] = din[32'(sel)*W +: W];
        end else begin : g_body
            assign dout[k*W +: W] = (32'(sel) >= k) ? din[(k-1)*W +: W] : din[k*W +: W];
        end
    end
endmodule

// File: rtl/frfcfs_picker.sv
module frfcfs_picker
    import frfcfs_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int NBANK  = DEF_NBANK,
    parameter int ROW_W  = DEF_ROW_W,
    parameter int TIME_W = DEF_TIME_W,
    parameter int BANK_W = $clog2(NBANK),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sched_mode,
    input  logic                    pick_req,
    input  logic [TIME_W-1:0]       now_cycle,
    input  logic [DEPTH-1:0]        ent_valid,
    input  logic [DEPTH*BANK_W-1:0] ent_bank,
    input  logic [DEPTH*ROW_W-1:0]  ent_row,
    input  logic [NBANK*ROW_W-1:0]  bank_open_row,
    input  logic [NBANK*TIME_W-1:0] bank_ready_at,
    output logic                    pick_valid,
    output logic [IDX_W-1:0]        pick_idx,
    output logic [DEPTH-1:0]        ord_valid,
    output logic [DEPTH*BANK_W-1:0] ord_bank,
    output logic [DEPTH*ROW_W-1:0]  ord_row
);
    typedef struct packed {
        logic                    pick_valid;
        logic [IDX_W-1:0]        pick_idx;
        logic [DEPTH-1:0]        ord_valid;
        logic [DEPTH*BANK_W-1:0] ord_bank;
        logic [DEPTH*ROW_W-1:0]  ord_row;
    } state_t;

    state_t state_d, state_q;

    logic [NBANK-1:0]        early_mask;
    logic [IDX_W-1:0]        sel_idx;
    logic [DEPTH-1:0]        rot_valid;
    logic [DEPTH*BANK_W-1:0] rot_bank;
    logic [DEPTH*ROW_W-1:0]  rot_row;
    logic                    fr_mode;

    assign fr_mode = (sched_mode == MODE_FRFCFS);

    frfcfs_earliest #(
        .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .TIME_W(TIME_W)
    ) u_earliest (
        .ent_valid     (ent_valid),
        .ent_bank      (ent_bank),
        .bank_ready_at (bank_ready_at),
        .early_mask    (early_mask)
    );

    frfcfs_scan #(
        .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .TIME_W(TIME_W), .IDX_W(IDX_W)
    ) u_scan (
        .fr_mode       (fr_mode),
        .now_cycle     (now_cycle),
        .ent_valid     (ent_valid),
        .ent_bank      (ent_bank),
        .ent_row       (ent_row),
        .bank_open_row (bank_open_row),
        .bank_ready_at (bank_ready_at),
        .early_mask    (early_mask),
        .sel_idx       (sel_idx)
    );

    frfcfs_rotate #(.DEPTH(DEPTH), .W(1), .IDX_W(IDX_W)) u_rot_valid (
        .sel (sel_idx), .din (ent_valid), .dout (rot_valid)
    );
    frfcfs_rotate #(.DEPTH(DEPTH), .W(BANK_W), .IDX_W(IDX_W)) u_rot_bank (
        .sel (sel_idx), .din (ent_bank), .dout (rot_bank)
    );
    frfcfs_rotate #(.DEPTH(DEPTH), .W(ROW_W), .IDX_W(IDX_W)) u_rot_row (
        .sel (sel_idx), .din (ent_row), .dout (rot_row)
    );

    always_comb begin
        state_d            = state_q;
        state_d.pick_valid = 1'b0;
        if (pick_req && ent_valid[0]) begin
            state_d.pick_valid = 1'b1;
            state_d.pick_idx   = sel_idx;
            state_d.ord_valid  = rot_valid;
            state_d.ord_bank   = rot_bank;
            state_d.ord_row    = rot_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pick_valid = state_q.pick_valid;
    assign pick_idx   = state_q.pick_idx;
    assign ord_valid  = state_q.ord_valid;
    assign ord_bank   = state_q.ord_bank;
    assign ord_row    = state_q.ord_row;
endmodule

// File: rtl/frfcfs_picker_chk.sv
module frfcfs_picker_chk #(
    parameter int DEPTH  = 16,
    parameter int NBANK  = 8,
    parameter int ROW_W  = 16,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sched_mode,
    input logic                    pick_req,
    input logic [DEPTH-1:0]        ent_valid,
    input logic [DEPTH*BANK_W-1:0] ent_bank,
    input logic [DEPTH*ROW_W-1:0]  ent_row,
    input logic [NBANK*ROW_W-1:0]  bank_open_row,
    input logic                    pick_valid,
    input logic [IDX_W-1:0]        pick_idx,
    input logic [DEPTH-1:0]        ord_valid,
    input logic [DEPTH*BANK_W-1:0] ord_bank,
    input logic [DEPTH*ROW_W-1:0]  ord_row
);
    logic                    p_seen, p_mode, p_req;
    logic [DEPTH-1:0]        p_valid;
    logic [DEPTH*BANK_W-1:0] p_bank;
    logic [DEPTH*ROW_W-1:0]  p_row;
    logic [NBANK*ROW_W-1:0]  p_open;
    logic                    p_any_hit;
    logic [BANK_W-1:0]       hb;
    logic [BANK_W-1:0]       head_bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_seen <= 1'b0; p_mode <= 1'b0; p_req <= 1'b0;
            p_valid <= '0; p_bank <= '0; p_row <= '0; p_open <= '0;
        end else begin
            p_seen <= 1'b1; p_mode <= sched_mode; p_req <= pick_req;
            p_valid <= ent_valid; p_bank <= ent_bank; p_row <= ent_row;
            p_open <= bank_open_row;
        end
    end

    always_comb begin
        p_any_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            hb = p_bank[i*BANK_W +: BANK_W];
            if (p_valid[i] && (p_open[hb*ROW_W +: ROW_W] == p_row[i*ROW_W +: ROW_W]))
                p_any_hit = 1'b1;
        end
    end

    assign head_bank = ord_bank[0 +: BANK_W];

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (p_seen && p_req && p_valid[0]));

    a_r9_empty_no_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (p_seen && p_req && !p_valid[0]) |-> !pick_valid);

    a_r2_fcfs_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && !p_mode) |->
            (pick_idx == '0 && ord_valid == p_valid && ord_bank == p_bank && ord_row == p_row));

    a_r7_head_is_chosen: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (ord_bank[0 +: BANK_W] == p_bank[32'(pick_idx)*BANK_W +: BANK_W] &&
                        ord_row[0 +: ROW_W] == p_row[32'(pick_idx)*ROW_W +: ROW_W]));

    a_r7_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ($countones(ord_valid) == $countones(p_valid)));

    a_r3_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && p_mode && p_any_hit) |->
            (p_open[head_bank*ROW_W +: ROW_W] == ord_row[0 +: ROW_W]));
endmodule

bind frfcfs_picker frfcfs_picker_chk #(
    .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode), .pick_req(pick_req),
    .ent_valid(ent_valid), .ent_bank(ent_bank), .ent_row(ent_row),
    .bank_open_row(bank_open_row), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .ord_valid(ord_valid), .ord_bank(ord_bank), .ord_row(ord_row)
);

// File: tb/frfcfs_picker_bench.sv
`timescale 1ns/1ps
module frfcfs_picker_bench;
    localparam int DEPTH = 16, NB = 8, BW = 3, RW = 16, TW = 32, IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sched_mode = 1'b0;
    logic pick_req = 1'b0;
    logic [TW-1:0]       now_cycle = '0;
    logic [DEPTH-1:0]    ent_valid = '0;
    logic [DEPTH*BW-1:0] ent_bank = '0;
    logic [DEPTH*RW-1:0] ent_row = '0;
    logic [NB*RW-1:0]    bank_open_row = '0;
    logic [NB*TW-1:0]    bank_ready_at = '0;
    logic                pick_valid;
    logic [IW-1:0]       pick_idx;
    logic [DEPTH-1:0]    ord_valid;
    logic [DEPTH*BW-1:0] ord_bank;
    logic [DEPTH*RW-1:0] ord_row;

    always #4 clk = ~clk;

    frfcfs_picker u_frfcfs_picker (
        .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode), .pick_req(pick_req),
        .now_cycle(now_cycle), .ent_valid(ent_valid), .ent_bank(ent_bank),
        .ent_row(ent_row), .bank_open_row(bank_open_row), .bank_ready_at(bank_ready_at),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .ord_valid(ord_valid),
        .ord_bank(ord_bank), .ord_row(ord_row)
    );

    int checks = 0;
    int errors = 0;

    bit          m_v   [DEPTH];
    int unsigned m_b   [DEPTH];
    int unsigned m_r   [DEPTH];
    int unsigned m_open[NB];
    int unsigned m_rdy [NB];
    int unsigned m_now;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_b[i] = 0; m_r[i] = 0; end
        for (int b = 0; b < NB; b++) begin m_open[b] = 1000; m_rdy[b] = 1000; end
        m_now = 0;
    endtask

    function automatic int model_pick(input bit fr);
        int unsigned mn = 32'hFFFF_FFFF;
        if (!fr) return 0;
        for (int i = 0; i < DEPTH; i++)
            if (m_v[i] && m_r[i] == m_open[m_b[i]]) return i;
        for (int i = 0; i < DEPTH; i++)
            if (m_v[i] && m_rdy[m_b[i]] < mn) mn = m_rdy[m_b[i]];
        for (int i = 0; i < DEPTH; i++)
            if (m_v[i] && (m_rdy[m_b[i]] <= m_now || m_rdy[m_b[i]] == mn)) return i;
        return 0;
    endfunction

    // Drive the model at a falling edge, pulse the strobe, sample one cycle later.
    task automatic run_pick(input bit fr, input string req, input bit check_pre);
        int e;
        int pos;
        int order[DEPTH];
        bit q_ok;
        @(negedge clk);
        sched_mode = fr;
        now_cycle  = m_now;
        for (int i = 0; i < DEPTH; i++) begin
            ent_valid[i]          = m_v[i];
            ent_bank[i*BW +: BW]  = BW'(m_b[i]);
            ent_row[i*RW +: RW]   = RW'(m_r[i]);
        end
        for (int b = 0; b < NB; b++) begin
            bank_open_row[b*RW +: RW] = RW'(m_open[b]);
            bank_ready_at[b*TW +: TW] = TW'(m_rdy[b]);
        end
        pick_req = 1'b1;
        #1;
        if (check_pre) check(pick_valid == 1'b0, "R8 no combinational response", pick_valid, 0);
        @(negedge clk);
        pick_req = 1'b0;
        e = model_pick(fr);
        check(pick_valid == 1'b1, {req, " valid"}, pick_valid, 1);
        check(int'(pick_idx) == e, {req, " index"}, pick_idx, e);
        order[0] = e;
        pos = 1;
        for (int i = 0; i < DEPTH; i++) if (i != e) begin order[pos] = i; pos++; end
        q_ok = 1;
        for (int k = 0; k < DEPTH; k++) begin
            if (ord_valid[k] != m_v[order[k]]) q_ok = 0;
            if (int'(ord_bank[k*BW +: BW]) != m_b[order[k]]) q_ok = 0;
            if (int'(ord_row[k*RW +: RW]) != m_r[order[k]]) q_ok = 0;
        end
        check(q_ok, "R7 reordered queue", pos, DEPTH);
    endtask

    initial begin : main
        logic [DEPTH-1:0]    sv_v;
        logic [DEPTH*BW-1:0] sv_b;
        logic [DEPTH*RW-1:0] sv_r;
        clear_model();
        repeat (3) @(negedge clk);
        check(pick_valid == 1'b0, "R1 reset pick_valid", pick_valid, 0);
        check(ord_valid == '0, "R1 reset ord_valid", ord_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pick_valid == 1'b0 && ord_valid == '0, "R1 after release", ord_valid, 0);

        // R2: FCFS ignores a row hit further back
        clear_model();
        for (int i = 0; i < 8; i++) begin m_v[i] = 1; m_b[i] = i; m_r[i] = i + 1; end
        m_open[5] = 6; m_rdy[3] = 0; m_now = 10;
        run_pick(1'b0, "R2 fcfs", 1'b1);
        @(negedge clk);
        check(pick_valid == 1'b0, "R8 pulse one cycle", pick_valid, 0);

        // R3 + R4: two hits at 3 and 6, slot 1 is ready now
        clear_model();
        for (int i = 0; i < 8; i++) begin m_v[i] = 1; m_b[i] = i; m_r[i] = 50 + i; end
        m_rdy[1] = 0; m_now = 5;
        m_open[3] = 53; m_open[6] = 56;
        run_pick(1'b1, "R3 R4 oldest hit over ready slot", 1'b0);
        check(int'(pick_idx) == 3, "R4 hit index", pick_idx, 3);

        // R5: no hit, slot 2 bank idle now
        clear_model();
        for (int i = 0; i < 4; i++) begin m_v[i] = 1; m_b[i] = i; m_r[i] = 7; end
        m_rdy[0] = 100; m_rdy[1] = 90; m_rdy[2] = 40; m_rdy[3] = 20; m_now = 50;
        run_pick(1'b1, "R5 idle fallback", 1'b0);
        check(int'(pick_idx) == 2, "R5 index", pick_idx, 2);

        // R6 + R10: tie at 25 on banks 1 and 3; invalid slot 4 hits and is earliest
        clear_model();
        for (int i = 0; i < 4; i++) begin m_v[i] = 1; m_b[i] = i; m_r[i] = 9; end
        m_b[4] = 4; m_r[4] = 9; m_open[4] = 9; m_rdy[4] = 10;
        m_rdy[0] = 30; m_rdy[1] = 25; m_rdy[2] = 40; m_rdy[3] = 25; m_now = 0;
        run_pick(1'b1, "R6 R10 tie, invalid ignored", 1'b0);
        check(int'(pick_idx) == 1, "R10 invalid hit skipped", pick_idx, 1);
        m_rdy[1] = 26;
        run_pick(1'b1, "R6 single earliest", 1'b0);
        check(int'(pick_idx) == 3, "R6 earliest bank only", pick_idx, 3);

        // R9: empty queue strobe
        sv_v = ord_valid; sv_b = ord_bank; sv_r = ord_row;
        @(negedge clk);
        ent_valid = '0; ent_row = '1; pick_req = 1'b1;
        @(negedge clk);
        pick_req = 1'b0;
        check(pick_valid == 1'b0, "R9 empty no pick", pick_valid, 0);
        check(ord_valid == sv_v && ord_bank == sv_b && ord_row == sv_r,
              "R9 queue unchanged", ord_valid, sv_v);

        // Sweep over every queue length with narrow rows and times
        for (int len = 1; len <= DEPTH; len++) begin
            for (int t = 0; t < 40; t++) begin
                for (int i = 0; i < DEPTH; i++) begin
                    m_v[i] = (i < len);
                    m_b[i] = $urandom_range(NB - 1);
                    m_r[i] = $urandom_range(5);
                end
                for (int b = 0; b < NB; b++) begin
                    m_open[b] = $urandom_range(5) + ((t % 3 == 0) ? 10 : 0);
                    m_rdy[b]  = $urandom_range(15);
                end
                m_now = $urandom_range(12);
                run_pick((t % 8) != 7, "R3 R5 R6 sweep", 1'b0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule